// File: doc/BRIEF.md
# Burst Serial Port with Delayed Completion Pulse

This block is a synchronous serial port that moves fixed-length frames over a data-out line while collecting the same number of bits from a data-in line. It works either as the clock master, where it makes the serial clock by dividing the system clock, or as a clock follower, where an external serial clock paces each bit. Frames to send are pushed into a 16-entry transmit queue. Received frames are placed into a 16-entry receive queue.

A single configuration write picks the clock source, frame length, single-frame or burst operation, frame count and the hold-off option, and can also arm a transfer. In burst operation the port sends the programmed number of frames back to back. It signals completion once, after the final frame. With the hold-off option set in master mode, the completion pulse comes half a serial clock later. In burst operation the same option also leaves a half-clock idle gap after every frame.

Top module: `ser_burst_port`

Configuration word layout: bits [2:0] clock select, bit 3 hold-off, bit 4 burst enable, bits [8:5] frame count, bits [12:9] frame length, bit 13 arm.

## Requirements
- R1: Clock-select codes 0 to 6 make the port master. `sck_out` idles low and each level lasts 2^code system clocks. Code 7 makes it a follower that is paced by `sck_in`, with `sck_out` held low.
- R2: Timing is mode 00. The first bit is presented on `sdo` when a frame starts, and `sdo` moves to the next bit on each falling serial edge. `sdi` is sampled on each rising serial edge. Bits go most significant first, and output bit k is paired with input bit k.
- R3: A frame-length code N gives N-bit frames, so code 8 gives 8-bit frames and code 0 gives 16-bit frames. Bits N-1..0 of a transmit entry are sent. A received frame lands in bits N-1..0 of its receive entry, with the upper bits zero.
- R4: With burst enable at 0, an arm sends exactly one frame, raises one completion pulse, and then leaves the port idle.
- R5: `irq` is a one-cycle pulse. In master mode without hold-off it rises 2*N*H system clocks after the frame starts, where H is the half period.
- R6: In master mode with hold-off set, the completion pulse comes H system clocks later than without it.
- R7: In follower mode the hold-off bit does not change when the completion pulse occurs.
- R8: In burst operation the frame-count code C gives C frames, with code 0 giving 16. No pulse is raised after any frame other than the last one.
- R9: In master burst operation with hold-off set, each frame is followed by H system clocks with `sck_out` low before the next frame starts.
- R10: A transfer starts only once the transmit queue holds at least the frame count (1 for a single frame). Until then the arm stays pending, and the transfer starts on the cycle after the queue reaches that level.
- R11: Both queues hold 16 entries. `tx_full` is raised at 16, and a push to a full transmit queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration word (layout above) |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Frame to send |
| tx_full | output | 1 | Transmit queue holds 16 entries |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue is empty |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | External serial clock for follower mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | Completion pulse |

## Verification
The hardest case to reach is a burst that has been armed but is starved of data. In that state the start has to wait, the arm has to stay pending, and the frame timing has to begin exactly one cycle after the last needed push. The stimulus reaches it by arming a three-frame burst with only two entries queued, watching the serial clock stay low, and then pushing the third entry. The same approach shows the drop on a full queue: sixteen frames are drained by a code-0 burst, and then a single-frame arm must stay idle. A bench model predicts every serial clock level, data bit and completion cycle from the half period, length, count and hold-off.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DW = 16;
  localparam logic [2:0] SEL_FOLLOW = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} eng_st_t;

  typedef struct packed {
    logic [3:0] len_code;
    logic [3:0] cnt_code;
    logic       burst;
    logic       hold;
    logic [2:0] sel;
  } cfg_t;

  // system clocks per serial clock level
  function automatic logic [6:0] half_cycles(input logic [2:0] sel);
    return 7'd1 << sel;
  endfunction

  function automatic logic [4:0] bits_of(input logic [3:0] code);
    return (code == 4'd0) ? 5'd16 : {1'b0, code};
  endfunction

  function automatic logic [4:0] frames_of(input logic burst, input logic [3:0] code);
    if (!burst) return 5'd1;
    return (code == 4'd0) ? 5'd16 : {1'b0, code};
  endfunction

  function automatic logic [DW-1:0] low_mask(input logic [4:0] n);
    return (n >= 5'd16) ? '1 : ((16'd1 << n) - 16'd1);
  endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) r <= '0;
    else        r <= {r[STAGES-2:0], d};

  assign q = r[STAGES-1];
endmodule

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != LW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
    end

  assign rdata = mem[rptr];
  assign level = cnt;

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level == LW'(DEPTH)) |=> level == $past(level));
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/ser_engine.sv
module ser_engine
  import ser_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic          go,
  input  logic [LW-1:0] tx_level,
  input  logic [DW-1:0] tx_rdata,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          sdi_raw,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_wdata,
  output logic          sck_out,
  output logic          sdo,
  output logic          irq
);
  eng_st_t       st;
  logic          armed, sck_q, s_prev, irq_q;
  logic [6:0]    hcnt;
  logic [5:0]    half;
  logic [4:0]    bitcnt, left;
  logic [DW-1:0] txsr, rxsr;

  logic       master;
  logic [6:0] hlen;
  logic [4:0] nbits, need;
  logic [3:0] msb_idx;
  assign master  = cfg.sel != SEL_FOLLOW;
  assign hlen    = half_cycles(cfg.sel);
  assign nbits   = bits_of(cfg.len_code);
  assign need    = frames_of(cfg.burst, cfg.cnt_code);
  assign msb_idx = 4'(nbits - 5'd1);

  // named events
  logic start_evt, half_end, rise_evt, fall_evt, frame_end, finish_evt, next_evt, last_frame;
  assign start_evt  = (st == ST_IDLE) && armed && (int'(tx_level) >= int'(need));
  assign half_end   = master && (st != ST_IDLE) && (hcnt == 7'd0);
  assign rise_evt   = (st == ST_RUN) && (master ? (half_end && !half[0]) : (sck_s && !s_prev));
  assign fall_evt   = (st == ST_RUN) && (master ? (half_end && half[0]) : (!sck_s && s_prev));
  assign frame_end  = fall_evt && (master ? (half == ({nbits, 1'b0} - 6'd1)) : (bitcnt == nbits));
  assign last_frame = left == 5'd1;
  assign finish_evt = (frame_end && !(master && cfg.hold)) || ((st == ST_GAP) && half_end);
  assign next_evt   = finish_evt && !last_frame;

  assign tx_pop   = start_evt || next_evt;
  assign rx_push  = frame_end;
  assign rx_wdata = rxsr & low_mask(nbits);
  assign sck_out  = master && sck_q;
  assign sdo      = txsr[msb_idx];
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; armed <= 1'b0; sck_q <= 1'b0; s_prev <= 1'b0; irq_q <= 1'b0;
      hcnt <= '0; half <= '0; bitcnt <= '0; left <= '0; txsr <= '0; rxsr <= '0;
    end else begin
      s_prev <= sck_s;
      irq_q  <= finish_evt && last_frame;
      if (start_evt) armed <= 1'b0;
      else if (go)   armed <= 1'b1;
      case (st)
        ST_IDLE: if (start_evt) begin
          st <= ST_RUN; txsr <= tx_rdata; hcnt <= hlen - 7'd1;
          half <= '0; bitcnt <= '0; sck_q <= 1'b0; left <= need;
        end
        ST_RUN: begin
          if (master) begin
            if (half_end) begin
              hcnt <= hlen - 7'd1; half <= half + 6'd1; sck_q <= !half[0];
            end else hcnt <= hcnt - 7'd1;
          end
          if (rise_evt) begin
            rxsr   <= {rxsr[DW-2:0], master ? sdi_raw : sdi_s};
            bitcnt <= bitcnt + 5'd1;
          end
          if (fall_evt && !frame_end) txsr <= txsr << 1;
          if (frame_end && master && cfg.hold) st <= ST_GAP;
        end
        ST_GAP: if (!half_end) hcnt <= hcnt - 7'd1;
        default: st <= ST_IDLE;
      endcase
      if (next_evt) begin
        st <= ST_RUN; txsr <= tx_rdata; hcnt <= hlen - 7'd1;
        half <= '0; bitcnt <= '0; sck_q <= 1'b0; left <= left - 5'd1;
      end else if (finish_evt) st <= ST_IDLE;
    end

  a_r8_irq_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(left == 5'd1));
  a_r1_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (master && st == ST_RUN && hcnt != 7'd0) |=> $stable(sck_q));
  a_r9_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> !sck_q);
  a_r7_follow_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> st != ST_GAP);
  a_r1_follow_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !sck_out);
endmodule

// File: rtl/ser_burst_port.sv
module ser_burst_port
  import ser_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [13:0]   cfg_wdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_data,
  output logic          tx_full,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_empty,
  output logic          sck_out,
  input  logic          sck_in,
  output logic          sdo,
  input  logic          sdi,
  output logic          irq
);
  cfg_t          cfg_q;
  logic          go, tx_pop, rx_push, sck_s, sdi_s;
  logic [LW-1:0] tx_level, rx_level;
  logic [DW-1:0] tx_rdata, rx_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata[12:0]);

  assign go = cfg_wr && cfg_wdata[13];

  ser_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (.clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s));
  ser_sync #(.STAGES(SYNC_STAGES)) u_sdi_sync (.clk(clk), .rst_n(rst_n), .d(sdi),    .q(sdi_s));

  ser_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_rdata), .level(tx_level));

  ser_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_data), .level(rx_level));

  ser_engine #(.LW(LW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .go(go), .tx_level(tx_level),
    .tx_rdata(tx_rdata), .sck_s(sck_s), .sdi_s(sdi_s), .sdi_raw(sdi),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_wdata(rx_wdata),
    .sck_out(sck_out), .sdo(sdo), .irq(irq));

  assign tx_full  = tx_level == LW'(FIFO_DEPTH);
  assign rx_empty = rx_level == '0;

  a_r10_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_level != '0);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/ser_burst_port_test.sv
module ser_burst_port_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, sck_in = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic [15:0] tx_data = '0, rx_data;
  logic        tx_full, rx_empty, sck_out, sdo, sdi, irq;
  logic        follow_tb = 1'b0, sdi_drv = 1'b0, inv_tb = 1'b0;

  int nrun = 0, nfail = 0, edge_n = 0;
  int txq[$];

  always #4 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  assign sdi = follow_tb ? sdi_drv : (sdo ^ inv_tb);

  ser_burst_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdi(sdi), .irq(irq));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int hold, input int burst, input int cnt, input int len, input int arm);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {arm[0], len[3:0], cnt[3:0], burst[0], hold[0], sel[2:0]};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    tx_push = 1'b1; tx_data = v[15:0];
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop_chk(input string req, input int exp);
    chk(req, "rx not empty", rx_empty, 1'b0);
    chk(req, "rx frame", rx_data, exp[15:0]);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  // Behavioural master timeline: frame f starts at T1 + f*P, level i of H clocks each.
  task automatic check_master(input int h, input int nb, input int d, input int nf, input int inv);
    int t1, p;
    t1 = edge_n + 1;
    p  = (2 * nb + d) * h;
    for (int k = 0; k < nf * p + 5; k++) begin
      int m, f, r, i;
      string tag;
      @(negedge clk);
      m = edge_n - t1;
      if (m < 0) continue;
      f = m / p; r = m % p; i = r / h;
      tag = (f < nf && i >= 2 * nb) ? "R9" : "R1";
      chk(tag, "sck level", sck_out, (f < nf) && (i < 2 * nb) && (i % 2 == 1));
      if (f < nf && i < 2 * nb)
        chk("R2", "sdo bit", sdo, (txq[f] >> (nb - 1 - i / 2)) & 1);
      tag = (m > nf * p) ? "R4" : (d != 0) ? "R6" : (nf > 1) ? "R8" : "R5";
      chk(tag, "irq", irq, m == nf * p);
    end
    for (int f = 0; f < nf; f++)
      pop_chk("R3", (txq[f] ^ (inv != 0 ? 32'hFFFF : 0)) & ((1 << nb) - 1));
    chk("R3", "rx drained", rx_empty, 1'b1);
  endtask

  task automatic follow_run(input int hold, input int val, input int sin, output int lat);
    follow_tb = 1'b1;
    push(val);
    cfg_write(7, hold, 0, 0, 8, 1);
    for (int b = 7; b >= 0; b--) begin
      sdi_drv = sin[b];
      repeat (4) @(negedge clk);
      chk("R2", "follower sdo bit", sdo, val[b]);
      chk("R1", "follower sck_out low", sck_out, 1'b0);
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
      sck_in = 1'b0;
    end
    lat = 0;
    while (!irq && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R5", "follower irq seen", irq, 1'b1);
    @(negedge clk);
    chk("R5", "follower irq one cycle", irq, 1'b0);
    pop_chk("R3", sin & 8'hFF);
    follow_tb = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin : main
    int lat0, lat1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset sck", sck_out, 1'b0);
    chk("R5", "reset irq", irq, 1'b0);
    chk("R11", "reset tx_full", tx_full, 1'b0);
    chk("R11", "reset rx_empty", rx_empty, 1'b1);

    // single 8-bit frame, fastest clock, loopback
    txq = {32'hA5}; push(txq[0]);
    cfg_write(0, 0, 0, 0, 8, 1);
    check_master(1, 8, 0, 1, 0);

    // single frame with hold-off, H=4, inverted loopback
    txq = {32'h3C}; inv_tb = 1'b1; push(txq[0]);
    cfg_write(2, 1, 0, 0, 8, 1);
    check_master(4, 8, 1, 1, 1);
    inv_tb = 1'b0;

    // 16-bit frame, slowest clock
    txq = {32'hC3A1}; push(txq[0]);
    cfg_write(6, 0, 0, 0, 0, 1);
    check_master(64, 16, 0, 1, 0);

    // burst of 3 five-bit frames with gaps, H=2
    txq = {32'h15, 32'h0A, 32'h1E};
    foreach (txq[j]) push(txq[j]);
    cfg_write(1, 1, 1, 3, 5, 1);
    check_master(2, 5, 1, 3, 0);

    // starved burst: arm with 2 of 3 queued
    txq = {32'h9, 32'h6, 32'hF};
    push(txq[0]); push(txq[1]);
    cfg_write(0, 0, 1, 3, 4, 1);
    repeat (20) begin
      @(negedge clk);
      chk("R10", "starved sck", sck_out, 1'b0);
      chk("R10", "starved irq", irq, 1'b0);
    end
    push(txq[2]);
    check_master(1, 4, 0, 3, 0);

    // fill to 16, drop one, burst of 16 (code 0)
    txq = {};
    for (int j = 0; j < 16; j++) begin
      txq.push_back((j * 3 + 1) & 3);
      push(txq[j]);
    end
    chk("R11", "tx_full at 16", tx_full, 1'b1);
    push(2);
    cfg_write(0, 0, 1, 0, 2, 1);
    check_master(1, 2, 0, 16, 0);
    chk("R11", "tx_full after drain", tx_full, 1'b0);
    // dropped push left nothing: a single-frame arm must wait
    cfg_write(0, 0, 0, 0, 8, 1);
    repeat (30) begin
      @(negedge clk);
      chk("R11", "no stray frame", sck_out, 1'b0);
    end
    txq = {32'h5A}; push(txq[0]);
    check_master(1, 8, 0, 1, 0);

    // follower mode, hold-off clear then set
    follow_run(0, 32'h96, 32'h4D, lat0);
    follow_run(1, 32'h69, 32'hB2, lat1);
    chk("R7", "follower latency unchanged by hold-off", lat1, lat0);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule